// File: doc/BRIEF.md
# Per-Block Write Protection Manager

This block holds the write-protection state of every erase block in a memory array and answers, for each program or erase request, whether the addressed block may be modified. Each block carries two bits: a lock bit and a lock-down bit. Every block comes out of reset locked, with lock-down clear.

Software changes the state with two-cycle bus command sequences. A setup write arms the sequencer. The next write carries the confirm code, and that write's block address picks the target block. A write-protect input decides whether lock-down is enforced. While write-protect is low, a locked-down block keeps its lock state and refuses modification. While it is high, lock-down has no effect.

A separate read port returns the two state bits of any block for a signature-read path. A program or erase request is answered one cycle later with either a grant or a deny. A deny also sets a sticky protection-error status bit.

Top module: `blkprot_mgr`

## Requirements
- R1: After reset, every block reads locked with lock-down clear, `err_prot` is 0, and neither `op_grant` nor `op_deny` is asserted.
- R2: A command is a write of 8'h5A followed by a write of a confirm code: 8'h11 locks, 8'h22 unlocks, 8'h33 locks down. The block address of the confirm write selects the block. The address of the setup write is ignored.
- R3: Each `op_req` is answered in the next cycle by exactly one of `op_grant` or `op_deny`. The request is denied when the block is locked, when the block is locked down while `wp` is 0, or when the address is at or above NUM_BLK. The decision uses the state held before any command that completes on the same clock edge.
- R4: A lock command sets the lock bit. Only an unlock command clears it.
- R5: While `wp` is 0, lock and unlock commands on a locked-down block leave its lock bit unchanged.
- R6: While `wp` is 1, lock-down does not affect request decisions, and lock and unlock act on a locked-down block as on any other block.
- R7: A lock-down command sets the lock-down bit whether the block is locked or unlocked, and leaves the lock bit as it was. The lock-down bit is cleared only by reset.
- R8: A denied request sets `err_prot`, which then stays 1 until reset.
- R9: `rd_status` gives the state of block `rd_blk` as bit 0 = locked and bit 1 = locked-down. An address at or above NUM_BLK reads 2'b00.
- R10: A sequence whose second write is not one of the three confirm codes ends with no change; this includes a second 8'h5A. A write that is not 8'h5A while the sequencer is not armed is ignored. A confirm write addressed at or above NUM_BLK changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; restores all blocks to locked |
| wp | input | 1 | Write-protect level; 0 enforces lock-down |
| wr_en | input | 1 | Command bus write strobe, one cycle per write |
| wr_data | input | 8 | Command code of the write |
| wr_blk | input | BLK_W | Block address of the write |
| op_req | input | 1 | Program or erase request, one cycle |
| op_blk | input | BLK_W | Block addressed by the request |
| op_grant | output | 1 | Request allowed, one cycle after `op_req` |
| op_deny | output | 1 | Request refused, one cycle after `op_req` |
| err_prot | output | 1 | Sticky block-protected error |
| rd_blk | input | BLK_W | Block whose state is read |
| rd_status | output | 2 | {locked-down, locked} of `rd_blk` |

## Verification
The properties assume that `wp`, `op_blk` and the write inputs hold known, steady values at each rising edge. They also assume that `wr_en` and `op_req` are single-cycle strobes whose effect is judged at that edge. The bench changes every input only on the falling clock edge, so the value that the design and the checker sample at a rising edge is the one the bench set up half a period earlier. The frozen-lock and error-sticky properties depend on `wp` not changing between that edge and the state update. The bench keeps `wp` constant across each two-cycle command and each request for this reason.

// File: rtl/blkprot_pkg.sv
package blkprot_pkg;

  localparam logic [7:0] CMD_SETUP  = 8'h5A;
  localparam logic [7:0] CMD_LOCK   = 8'h11;
  localparam logic [7:0] CMD_UNLOCK = 8'h22;
  localparam logic [7:0] CMD_LDOWN  = 8'h33;

  typedef enum logic [1:0] {
    ACT_NONE   = 2'd0,
    ACT_LOCK   = 2'd1,
    ACT_UNLOCK = 2'd2,
    ACT_LDOWN  = 2'd3
  } act_e;

  typedef struct packed {
    logic ldown;
    logic locked;
  } blk_state_t;

  localparam blk_state_t BLK_RESET = '{ldown: 1'b0, locked: 1'b1};

  // Map the second write of a sequence to an action.
  function automatic act_e decode_confirm(input logic [7:0] code);
    act_e a;
    case (code)
      CMD_LOCK:   a = ACT_LOCK;
      CMD_UNLOCK: a = ACT_UNLOCK;
      CMD_LDOWN:  a = ACT_LDOWN;
      default:    a = ACT_NONE;
    endcase
    return a;
  endfunction

  // Lock bit held fixed by lock-down while write-protect is low.
  function automatic logic is_frozen(input blk_state_t s, input logic wp);
    return s.ldown & ~wp;
  endfunction

  // Program/erase refused for this block.
  function automatic logic is_protected(input blk_state_t s, input logic wp);
    return s.locked | is_frozen(s, wp);
  endfunction

  // State after an action is applied to one block.
  function automatic blk_state_t next_state(input blk_state_t s, input act_e a,
                                            input logic wp);
    blk_state_t n;
    n = s;
    case (a)
      ACT_LOCK:   if (!is_frozen(s, wp)) n.locked = 1'b1;
      ACT_UNLOCK: if (!is_frozen(s, wp)) n.locked = 1'b0;
      ACT_LDOWN:  n.ldown = 1'b1;
      default:    n = s;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/blkprot_seq.sv
module blkprot_seq
  import blkprot_pkg::*;
#(
  parameter int BLK_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [7:0]       wr_data,
  input  logic [BLK_W-1:0] wr_blk,
  output act_e             evt_act,
  output logic [BLK_W-1:0] evt_blk,
  output logic             armed
);

  logic armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
    end else if (wr_en) begin
      if (armed_q) armed_q <= 1'b0;
      else         armed_q <= (wr_data == CMD_SETUP);
    end
  end

  always_comb begin
    evt_act = ACT_NONE;
    if (wr_en && armed_q) evt_act = decode_confirm(wr_data);
  end

  assign evt_blk = wr_blk;
  assign armed   = armed_q;

endmodule

// File: rtl/blkprot_bank.sv
module blkprot_bank
  import blkprot_pkg::*;
#(
  parameter int NUM_BLK = 8,
  parameter int BLK_W   = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wp,
  input  act_e               evt_act,
  input  logic [BLK_W-1:0]   evt_blk,
  output logic [NUM_BLK-1:0] lock_vec,
  output logic [NUM_BLK-1:0] ldn_vec
);

  for (genvar g = 0; g < NUM_BLK; g++) begin : g_blk
    blk_state_t st_q;
    logic       hit;

    assign hit = (evt_act != ACT_NONE) && (evt_blk == BLK_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   st_q <= BLK_RESET;
      else if (hit) st_q <= next_state(st_q, evt_act, wp);
    end

    assign lock_vec[g] = st_q.locked;
    assign ldn_vec[g]  = st_q.ldown;
  end

endmodule

// File: rtl/blkprot_gate.sv
module blkprot_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic op_req,
  input  logic req_prot,
  output logic op_grant,
  output logic op_deny,
  output logic err_prot
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_grant <= 1'b0;
      op_deny  <= 1'b0;
      err_prot <= 1'b0;
    end else begin
      op_grant <= op_req & ~req_prot;
      op_deny  <= op_req &  req_prot;
      if (op_req && req_prot) err_prot <= 1'b1;
    end
  end

endmodule

// File: rtl/blkprot_mgr.sv
module blkprot_mgr
  import blkprot_pkg::*;
#(
  parameter  int NUM_BLK = 8,
  localparam int BLK_W   = (NUM_BLK > 1) ? $clog2(NUM_BLK) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wp,
  input  logic             wr_en,
  input  logic [7:0]       wr_data,
  input  logic [BLK_W-1:0] wr_blk,
  input  logic             op_req,
  input  logic [BLK_W-1:0] op_blk,
  output logic             op_grant,
  output logic             op_deny,
  output logic             err_prot,
  input  logic [BLK_W-1:0] rd_blk,
  output logic [1:0]       rd_status
);

  act_e               evt_act;
  logic [BLK_W-1:0]   evt_blk;
  logic               armed;
  logic [NUM_BLK-1:0] lock_vec;
  logic [NUM_BLK-1:0] ldn_vec;
  blk_state_t         req_state;
  logic               req_valid;
  logic               req_prot;
  blk_state_t         rd_state;

  blkprot_seq #(.BLK_W(BLK_W)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .wr_blk  (wr_blk),
    .evt_act (evt_act),
    .evt_blk (evt_blk),
    .armed   (armed)
  );

  blkprot_bank #(.NUM_BLK(NUM_BLK), .BLK_W(BLK_W)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .wp       (wp),
    .evt_act  (evt_act),
    .evt_blk  (evt_blk),
    .lock_vec (lock_vec),
    .ldn_vec  (ldn_vec)
  );

  // Select the requested block; an unmatched address stays invalid.
  always_comb begin
    req_state = '0;
    req_valid = 1'b0;
    rd_state  = '0;
    for (int i = 0; i < NUM_BLK; i++) begin
      if (op_blk == BLK_W'(i)) begin
        req_state = '{ldown: ldn_vec[i], locked: lock_vec[i]};
        req_valid = 1'b1;
      end
      if (rd_blk == BLK_W'(i)) rd_state = '{ldown: ldn_vec[i], locked: lock_vec[i]};
    end
  end

  assign req_prot  = ~req_valid | is_protected(req_state, wp);
  assign rd_status = {rd_state.ldown, rd_state.locked};

  blkprot_gate u_gate (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_req   (op_req),
    .req_prot (req_prot),
    .op_grant (op_grant),
    .op_deny  (op_deny),
    .err_prot (err_prot)
  );

endmodule

// File: rtl/blkprot_chk.sv
module blkprot_chk
  import blkprot_pkg::*;
#(
  parameter int NUM_BLK = 8,
  parameter int BLK_W   = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               wp,
  input logic               op_req,
  input logic [BLK_W-1:0]   op_blk,
  input logic               op_grant,
  input logic               op_deny,
  input logic               err_prot,
  input act_e               evt_act,
  input logic [BLK_W-1:0]   evt_blk,
  input logic [NUM_BLK-1:0] lock_vec,
  input logic [NUM_BLK-1:0] ldn_vec
);

  // R3: one answer per request, never both
  p_one_answer_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(op_grant && op_deny));

  p_answer_needs_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (op_grant || op_deny) |-> $past(op_req));

  // R8: error follows a deny and persists
  p_deny_sets_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
    op_deny |-> err_prot);

  p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err_prot |=> err_prot);

  for (genvar g = 0; g < NUM_BLK; g++) begin : g_chk
    // R3: locked block is refused
    p_locked_denied_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (op_req && op_blk == BLK_W'(g) && lock_vec[g]) |=> op_deny);

    // R3, R5: locked-down block refused while wp low
    p_ldown_denied_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (op_req && op_blk == BLK_W'(g) && ldn_vec[g] && !wp) |=> op_deny);

    // R5: lock bit frozen under lock-down with wp low
    p_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (ldn_vec[g] && !wp) |=> $stable(lock_vec[g]));

    // R7: lock-down cleared only by reset
    p_ldown_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ldn_vec[g] |=> ldn_vec[g]);

    // R4: lock bit falls only through an unlock aimed at this block
    p_unlock_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(lock_vec[g]) |-> $past(evt_act == ACT_UNLOCK && evt_blk == BLK_W'(g)));
  end

endmodule

bind blkprot_mgr blkprot_chk #(.NUM_BLK(NUM_BLK), .BLK_W(BLK_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wp       (wp),
  .op_req   (op_req),
  .op_blk   (op_blk),
  .op_grant (op_grant),
  .op_deny  (op_deny),
  .err_prot (err_prot),
  .evt_act  (evt_act),
  .evt_blk  (evt_blk),
  .lock_vec (lock_vec),
  .ldn_vec  (ldn_vec)
);

// File: tb/blkprot_mgr_test.sv
`timescale 1ns/1ps
module blkprot_mgr_test;

  localparam int NB = 6;
  localparam int BW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wp = 1'b0;
  logic          wr_en = 1'b0;
  logic [7:0]    wr_data = '0;
  logic [BW-1:0] wr_blk = '0;
  logic          op_req = 1'b0;
  logic [BW-1:0] op_blk = '0;
  logic          op_grant, op_deny, err_prot;
  logic [BW-1:0] rd_blk = '0;
  logic [1:0]    rd_status;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  bit m_lock [8];
  bit m_ldn  [8];
  bit m_err;
  int unsigned seed = 32'h1234_5678;

  always #10 clk = ~clk;

  blkprot_mgr #(.NUM_BLK(NB)) uut (
    .clk(clk), .rst_n(rst_n), .wp(wp),
    .wr_en(wr_en), .wr_data(wr_data), .wr_blk(wr_blk),
    .op_req(op_req), .op_blk(op_blk),
    .op_grant(op_grant), .op_deny(op_deny), .err_prot(err_prot),
    .rd_blk(rd_blk), .rd_status(rd_status)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int unsigned rnd();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed >> 16;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 8; i++) begin
      m_lock[i] = (i < NB);
      m_ldn[i]  = 1'b0;
    end
    m_err = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    model_reset();
  endtask

  // One bus write; returns at the falling edge after it was sampled.
  task automatic wr(input logic [7:0] d, input int b);
    wr_en = 1'b1; wr_data = d; wr_blk = BW'(b);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Two-cycle command plus bench model update.
  task automatic cmd(input logic [7:0] code, input int b, input int first_b);
    bit frz;
    wr(8'h5A, first_b);
    wr(code, b);
    if (b < NB) begin
      frz = m_ldn[b] && !wp;
      if (code == 8'h11 && !frz) m_lock[b] = 1'b1;
      if (code == 8'h22 && !frz) m_lock[b] = 1'b0;
      if (code == 8'h33) m_ldn[b] = 1'b1;
    end
  endtask

  task automatic check_all(input string req);
    for (int b = 0; b < 8; b++) begin
      rd_blk = BW'(b);
      #1;
      chk(req, int'(rd_status), (b < NB) ? int'({m_ldn[b], m_lock[b]}) : 0);
    end
  endtask

  function automatic bit exp_prot(input int b);
    if (b >= NB) return 1'b1;
    return m_lock[b] || (m_ldn[b] && !wp);
  endfunction

  task automatic op_try(input int b, input string req);
    bit p;
    p = exp_prot(b);
    op_req = 1'b1; op_blk = BW'(b);
    @(negedge clk);
    op_req = 1'b0;
    chk(req, int'({op_grant, op_deny}), p ? 1 : 2);
    if (p) m_err = 1'b1;
    chk("R8", int'(err_prot), int'(m_err));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    check_all("R1");
    chk("R1", int'({op_grant, op_deny, err_prot}), 0);

    // R3, R8: locked block refused, error set
    op_try(0, "R3");

    // R2, R4: unlock every block, setup address differs from target
    for (int b = 0; b < NB; b++) begin
      cmd(8'h22, b, 7 - b);
      check_all("R2");
    end
    for (int b = 0; b < NB; b++) op_try(b, "R4");

    // R10: bad confirm, double setup, unarmed confirm
    cmd(8'h11, 1, 1);
    wr(8'h5A, 0); wr(8'h77, 0);
    check_all("R10");
    wr(8'h5A, 1); wr(8'h5A, 1); wr(8'h22, 1);
    check_all("R10");
    wr(8'h11, 2);
    check_all("R10");

    // R10, R9, R3: out-of-range addresses
    cmd(8'h11, 6, 0);
    cmd(8'h33, 7, 0);
    check_all("R9");
    op_try(6, "R3");
    op_try(7, "R3");

    // R5, R6, R7: directed lock-down walk on block 3
    wp = 1'b0;
    cmd(8'h33, 3, 0);
    check_all("R7");
    op_try(3, "R5");
    cmd(8'h11, 3, 0);
    check_all("R5");
    @(negedge clk); wp = 1'b1;
    op_try(3, "R6");
    cmd(8'h11, 3, 0);
    check_all("R6");
    cmd(8'h22, 3, 0);
    check_all("R6");
    cmd(8'h33, 1, 0);
    check_all("R7");

    // R3: decision uses state from before a same-edge unlock
    @(negedge clk); wp = 1'b0;
    cmd(8'h11, 4, 0);
    wr(8'h5A, 0);
    op_req = 1'b1; op_blk = 3'd4;
    wr(8'h22, 4);
    op_req = 1'b0;
    chk("R3", int'({op_grant, op_deny}), 1);
    m_lock[4] = 1'b0; m_err = 1'b1;
    op_try(4, "R3");

    // R4, R5, R6, R7: swept command mix
    for (int n = 0; n < 400; n++) begin
      int unsigned r;
      logic [7:0] code;
      r = rnd();
      wp = r[0];
      case (r[3:1] % 6)
        0, 1, 2: code = 8'h22;
        3, 4:    code = 8'h11;
        default: code = (r[6:4] == 0) ? 8'h33 : 8'h22;
      endcase
      cmd(code, int'(r[9:7]), int'(r[12:10]));
      check_all("R5");
      op_try(int'(r[15:13]), "R6");
    end

    // R1, R7, R8: reset clears lock-down and error
    do_reset();
    @(negedge clk);
    check_all("R1");
    chk("R8", int'(err_prot), 0);

    // R6: wp high, unlock now works on all blocks
    wp = 1'b1;
    for (int b = 0; b < NB; b++) cmd(8'h22, b, 0);
    check_all("R6");
    for (int b = 0; b < 8; b++) op_try(b, "R3");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule